// File: doc/BRIEF.md
# Double-Buffered Display Mixer Configuration Bank

This block holds the global settings of a display mixer in two copies. Software programs a pending (shadow) copy of the control word and the output size through a 32-bit register port, then raises an apply request. The pending values reach the active copy only at the next frame start, so the mixer never sees a half-updated configuration within a frame. The active copy drives dedicated output pins that the pixel pipeline consumes.

The bank also tracks frame events. A frame-done pulse and an error pulse each set a sticky interrupt status bit that software clears by writing 1. A single interrupt line combines every status bit with its enable. A busy flag covers the span from a frame start, with the mixer enabled, to the matching frame done. A second error flag records whether an error has happened in the current frame.

The register port is plain control access with no back-pressure. A write takes effect at the clock edge where `reg_wr_en` is high. `reg_rdata` is a combinational view of the addressed register, so it always reflects state as of the most recent edge. All pins are plain control and status signals, and there is no valid/ready stream at this block's edge.

Top module: `mixer_cfg_bank`

## Requirements
- R1: After reset, every register reads 0, every active output is 0 and `irq` is 0.
- R2: A write to offset 0x0 stores mixer enable (bit 0), finish interrupt enable (bit 4), error interrupt enable (bit 5) and writeback port (bits 13:12) into the pending copy. Reads of 0x0 return these bits with all other bits 0. Reads of any unmapped offset return 0.
- R3: A write to offset 0xC stores width minus one (bits 12:0) and height minus one (bits 28:16) into the pending copy. Reads return those fields with all other bits 0.
- R4: Writing 1 to bit 0 of offset 0xC-minus-4 (0x8) latches an apply request, and writing 0 there has no effect. Bit 0 of a read at 0x8 shows whether a request is pending.
- R5: At a frame start with a request pending, the active outputs take the pending values as they stood before that clock edge, and the request clears. A frame start with no request leaves the active outputs unchanged.
- R6: An apply write in the same cycle as a frame start commits at that same edge, and no request remains pending afterwards.
- R7: Writes to the pending copy never change the active outputs unless a commit happens.
- R8: A frame-done pulse sets status bit 0 and an error pulse sets status bit 1 at offset 0x4. Both bits are sticky.
- R9: Writing 1 to status bit 0 or bit 1 clears that bit. A set event in the same cycle takes priority over the clear.
- R10: `irq` is high whenever status bit 0 is set with the finish enable (0x0 bit 4), or status bit 1 is set with the error enable (0x0 bit 5). The enables come from the programmed copy.
- R11: Status bit 4 (busy) is loaded at each frame start with the active mixer enable that holds after that edge. It is cleared by frame done, and a frame start in the same cycle takes priority.
- R12: Status bit 5 is set by an error pulse and cleared by a frame start. The error pulse takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Byte offset for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the addressed register |
| frame_start | input | 1 | One-cycle pulse at each frame boundary |
| frame_done | input | 1 | One-cycle pulse when a frame completes |
| err_evt | input | 1 | One-cycle pulse on a mixer error |
| act_mix_en | output | 1 | Active mixer enable |
| act_wb_port | output | 2 | Active writeback port select |
| act_width_m1 | output | 13 | Active output width minus one |
| act_height_m1 | output | 13 | Active output height minus one |
| irq | output | 1 | Interrupt request |

## Verification
A write or an event applied at one rising edge is visible in the registered state, and so in `reg_rdata` and `irq`, straight after that edge. A commit moves the active outputs at the edge where the frame start is sampled, with no added latency. The reference model advances on the rising edge from the same inputs the design sees. All inputs change 1 ns after the falling edge, and every comparison is made exactly at the falling edge, half a period after the edge whose result is being judged. Directed checks insert an idle cycle before reading back, so each expected value is settled when it is sampled.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
  localparam int DATA_W  = 32;
  localparam int DIM_W   = 13;
  localparam int WB_W    = 2;
  localparam int NUM_EVT = 2;

  localparam logic [3:0] OFS_CTRL  = 4'h0;
  localparam logic [3:0] OFS_STAT  = 4'h4;
  localparam logic [3:0] OFS_APPLY = 4'h8;
  localparam logic [3:0] OFS_SIZE  = 4'hC;

  localparam int B_MIX_EN = 0;
  localparam int B_FIN_IE = 4;
  localparam int B_ERR_IE = 5;
  localparam int B_WB_LO  = 12;
  localparam int B_H_LO   = 16;
  localparam int B_BUSY   = 4;
  localparam int B_ELIVE  = 5;

  typedef struct packed {
    logic [WB_W-1:0] wb_port;
    logic            err_ie;
    logic            fin_ie;
    logic            mix_en;
  } ctrl_t;

  typedef struct packed {
    logic [DIM_W-1:0] h_m1;
    logic [DIM_W-1:0] w_m1;
  } size_t;

  function automatic ctrl_t ctrl_from_word(logic [DATA_W-1:0] w);
    ctrl_t c;
    c.mix_en  = w[B_MIX_EN];
    c.fin_ie  = w[B_FIN_IE];
    c.err_ie  = w[B_ERR_IE];
    c.wb_port = w[B_WB_LO +: WB_W];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_to_word(ctrl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[B_MIX_EN]          = c.mix_en;
    w[B_FIN_IE]          = c.fin_ie;
    w[B_ERR_IE]          = c.err_ie;
    w[B_WB_LO +: WB_W]   = c.wb_port;
    return w;
  endfunction

  function automatic size_t size_from_word(logic [DATA_W-1:0] w);
    size_t s;
    s.w_m1 = w[0 +: DIM_W];
    s.h_m1 = w[B_H_LO +: DIM_W];
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] size_to_word(size_t s);
    logic [DATA_W-1:0] w;
    w = '0;
    w[0 +: DIM_W]      = s.w_m1;
    w[B_H_LO +: DIM_W] = s.h_m1;
    return w;
  endfunction
endpackage

// File: rtl/mcb_shadow.sv
module mcb_shadow
  import mcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_size,
  input  logic              wr_apply,
  input  logic [DATA_W-1:0] wdata,
  input  logic              frame_start,
  output ctrl_t             sh_ctrl,
  output size_t             sh_size,
  output logic              pending,
  output ctrl_t             act_ctrl,
  output size_t             act_size,
  output logic              commit
);
  logic apply_req;

  assign apply_req = wr_apply & wdata[0];
  // A request raised in this very cycle also counts at a frame boundary.
  assign commit    = frame_start & (pending | apply_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_ctrl  <= '0;
      sh_size  <= '0;
      act_ctrl <= '0;
      act_size <= '0;
      pending  <= 1'b0;
    end else begin
      if (wr_ctrl) sh_ctrl <= ctrl_from_word(wdata);
      if (wr_size) sh_size <= size_from_word(wdata);
      if (commit) begin
        act_ctrl <= sh_ctrl;
        act_size <= sh_size;
        pending  <= 1'b0;
      end else if (apply_req) begin
        pending  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mcb_events.sv
module mcb_events
  import mcb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               frame_done,
  input  logic               err_evt,
  input  logic               clr_wr,
  input  logic [NUM_EVT-1:0] clr_bits,
  input  logic               run_en_next,
  output logic [NUM_EVT-1:0] sts,
  output logic               busy,
  output logic               err_live
);
  logic [NUM_EVT-1:0] set_vec;

  // index 0: frame finished, index 1: error
  assign set_vec = {err_evt, frame_done};

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_sticky
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     q <= 1'b0;
      else if (set_vec[i])            q <= 1'b1;
      else if (clr_wr && clr_bits[i]) q <= 1'b0;
    end
    assign sts[i] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      err_live <= 1'b0;
    end else begin
      if (frame_start)     busy <= run_en_next;
      else if (frame_done) busy <= 1'b0;

      if (err_evt)          err_live <= 1'b1;
      else if (frame_start) err_live <= 1'b0;
    end
  end
endmodule

// File: rtl/mcb_readout.sv
module mcb_readout
  import mcb_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0]  addr,
  input  ctrl_t              sh_ctrl,
  input  size_t              sh_size,
  input  logic               pending,
  input  logic [NUM_EVT-1:0] sts,
  input  logic               busy,
  input  logic               err_live,
  output logic [DATA_W-1:0]  rdata
);
  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFS_CTRL)) begin
      rdata = ctrl_to_word(sh_ctrl);
    end else if (addr == ADDR_W'(OFS_STAT)) begin
      rdata[NUM_EVT-1:0] = sts;
      rdata[B_BUSY]      = busy;
      rdata[B_ELIVE]     = err_live;
    end else if (addr == ADDR_W'(OFS_APPLY)) begin
      rdata[0] = pending;
    end else if (addr == ADDR_W'(OFS_SIZE)) begin
      rdata = size_to_word(sh_size);
    end
  end
endmodule

// File: rtl/mixer_cfg_bank.sv
module mixer_cfg_bank
  import mcb_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              frame_start,
  input  logic              frame_done,
  input  logic              err_evt,
  output logic              act_mix_en,
  output logic [WB_W-1:0]   act_wb_port,
  output logic [DIM_W-1:0]  act_width_m1,
  output logic [DIM_W-1:0]  act_height_m1,
  output logic              irq
);
  logic               wr_ctrl, wr_stat, wr_apply, wr_size;
  ctrl_t              sh_ctrl, act_ctrl;
  size_t              sh_size, act_size;
  logic               pending, commit, run_en_next;
  logic [NUM_EVT-1:0] sts, irq_en;
  logic               busy, err_live;

  assign wr_ctrl  = reg_wr_en && (reg_addr == ADDR_W'(OFS_CTRL));
  assign wr_stat  = reg_wr_en && (reg_addr == ADDR_W'(OFS_STAT));
  assign wr_apply = reg_wr_en && (reg_addr == ADDR_W'(OFS_APPLY));
  assign wr_size  = reg_wr_en && (reg_addr == ADDR_W'(OFS_SIZE));

  mcb_shadow u_shadow (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ctrl     (wr_ctrl),
    .wr_size     (wr_size),
    .wr_apply    (wr_apply),
    .wdata       (reg_wdata),
    .frame_start (frame_start),
    .sh_ctrl     (sh_ctrl),
    .sh_size     (sh_size),
    .pending     (pending),
    .act_ctrl    (act_ctrl),
    .act_size    (act_size),
    .commit      (commit)
  );

  // Busy follows the enable that will be active after this edge.
  assign run_en_next = commit ? sh_ctrl.mix_en : act_ctrl.mix_en;

  mcb_events u_events (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .frame_done  (frame_done),
    .err_evt     (err_evt),
    .clr_wr      (wr_stat),
    .clr_bits    (reg_wdata[NUM_EVT-1:0]),
    .run_en_next (run_en_next),
    .sts         (sts),
    .busy        (busy),
    .err_live    (err_live)
  );

  mcb_readout #(.ADDR_W(ADDR_W)) u_readout (
    .addr     (reg_addr),
    .sh_ctrl  (sh_ctrl),
    .sh_size  (sh_size),
    .pending  (pending),
    .sts      (sts),
    .busy     (busy),
    .err_live (err_live),
    .rdata    (reg_rdata)
  );

  assign irq_en        = {sh_ctrl.err_ie, sh_ctrl.fin_ie};
  assign irq           = |(sts & irq_en);
  assign act_mix_en    = act_ctrl.mix_en;
  assign act_wb_port   = act_ctrl.wb_port;
  assign act_width_m1  = act_size.w_m1;
  assign act_height_m1 = act_size.h_m1;
endmodule

// File: rtl/mcb_checker.sv
module mcb_checker
  import mcb_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              frame_start,
  input logic              frame_done,
  input logic              irq,
  input logic              act_mix_en,
  input logic [DIM_W-1:0]  act_width_m1,
  input logic [DIM_W-1:0]  sh_width,
  input logic              pending,
  input logic              fin_sts,
  input logic              fin_ie,
  input logic              busy
);
  logic apply_wr, ctrl_wr, fin_clr;
  assign apply_wr = reg_wr_en && reg_addr == ADDR_W'(OFS_APPLY) && reg_wdata[0];
  assign ctrl_wr  = reg_wr_en && reg_addr == ADDR_W'(OFS_CTRL);
  assign fin_clr  = reg_wr_en && reg_addr == ADDR_W'(OFS_STAT) && reg_wdata[0];

  assert_active_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_width_m1) && $stable(act_mix_en));

  assert_commit_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && pending |=> act_width_m1 == $past(sh_width));

  assert_pending_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !pending);

  assert_same_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && apply_wr |=> act_width_m1 == $past(sh_width));

  assert_fin_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> fin_sts);

  assert_fin_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fin_clr && !frame_done |=> !fin_sts);

  assert_irq_fin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && fin_ie && !ctrl_wr |=> irq);

  assert_busy_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !frame_start |=> !busy);
endmodule

bind mixer_cfg_bank mcb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr_en    (reg_wr_en),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .frame_start  (frame_start),
  .frame_done   (frame_done),
  .irq          (irq),
  .act_mix_en   (act_mix_en),
  .act_width_m1 (act_width_m1),
  .sh_width     (sh_size.w_m1),
  .pending      (pending),
  .fin_sts      (sts[0]),
  .fin_ie       (sh_ctrl.fin_ie),
  .busy         (busy)
);

// File: tb/test_mixer_cfg_bank.sv
`timescale 1ns/1ps
module test_mixer_cfg_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        frame_start = 1'b0, frame_done = 1'b0, err_evt = 1'b0;
  logic        act_mix_en, irq;
  logic [1:0]  act_wb_port;
  logic [12:0] act_width_m1, act_height_m1;

  int n_chk = 0, n_fail = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  mixer_cfg_bank i_mixer_cfg_bank (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
    .frame_done(frame_done), .err_evt(err_evt), .act_mix_en(act_mix_en),
    .act_wb_port(act_wb_port), .act_width_m1(act_width_m1),
    .act_height_m1(act_height_m1), .irq(irq));

  // Behavioural reference state
  logic [31:0] m_ctrl = 0, m_size = 0, m_act_ctrl = 0, m_act_size = 0;
  logic        m_pend = 0, m_fin = 0, m_err = 0, m_busy = 0, m_elive = 0;

  always @(posedge clk) begin
    logic ap, cm, en_nx;
    if (!rst_n) begin
      m_ctrl = 0; m_size = 0; m_act_ctrl = 0; m_act_size = 0;
      m_pend = 0; m_fin = 0; m_err = 0; m_busy = 0; m_elive = 0;
    end else begin
      ap    = reg_wr_en && reg_addr == 4'h8 && reg_wdata[0];
      cm    = frame_start && (m_pend || ap);
      en_nx = cm ? m_ctrl[0] : m_act_ctrl[0];
      if (frame_start) m_busy = en_nx;
      else if (frame_done) m_busy = 0;
      if (err_evt) m_elive = 1;
      else if (frame_start) m_elive = 0;
      if (frame_done) m_fin = 1;
      else if (reg_wr_en && reg_addr == 4'h4 && reg_wdata[0]) m_fin = 0;
      if (err_evt) m_err = 1;
      else if (reg_wr_en && reg_addr == 4'h4 && reg_wdata[1]) m_err = 0;
      if (cm) begin
        m_act_ctrl = m_ctrl; m_act_size = m_size; m_pend = 0;
      end else if (ap) m_pend = 1;
      if (reg_wr_en && reg_addr == 4'h0) m_ctrl = reg_wdata & 32'h0000_3031;
      if (reg_wr_en && reg_addr == 4'hC) m_size = reg_wdata & 32'h1FFF_1FFF;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [3:0] a);
    case (a)
      4'h0:    return m_ctrl;
      4'h4:    return {26'd0, m_elive, m_busy, 2'b00, m_err, m_fin};
      4'h8:    return {31'd0, m_pend};
      4'hC:    return m_size;
      default: return 32'd0;
    endcase
  endfunction

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!ended) begin
      chk("R5/R6/R7 active enable", {31'd0, act_mix_en}, {31'd0, m_act_ctrl[0]});
      chk("R5/R6/R7 active wb port", {30'd0, act_wb_port}, {30'd0, m_act_ctrl[13:12]});
      chk("R5/R6/R7 active size", {3'd0, act_height_m1, 3'd0, act_width_m1},
          m_act_size);
      chk("R10 irq", {31'd0, irq},
          {31'd0, (m_fin && m_ctrl[4]) || (m_err && m_ctrl[5])});
      case (reg_addr)
        4'h0:    chk("R2 control read", reg_rdata, m_read(reg_addr));
        4'h4:    chk("R8/R9/R11/R12 status read", reg_rdata, m_read(reg_addr));
        4'h8:    chk("R4 apply read", reg_rdata, m_read(reg_addr));
        4'hC:    chk("R3 size read", reg_rdata, m_read(reg_addr));
        default: chk("R2 unmapped read", reg_rdata, 32'd0);
      endcase
    end
  end

  task automatic put(logic wr, logic [3:0] a, logic [31:0] d,
                     logic fs, logic fd, logic ee);
    @(negedge clk); #1;
    reg_wr_en = wr; reg_addr = a; reg_wdata = d;
    frame_start = fs; frame_done = fd; err_evt = ee;
  endtask

  task automatic look(logic [3:0] a);
    put(1'b0, a, 32'd0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset read", reg_rdata, 32'd0);
    #1 rst_n = 1'b1;
    look(4'h4); chk("R1 status after reset", reg_rdata, 32'd0);
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);

    put(1, 4'h0, 32'hFFFF_FFFF, 0, 0, 0);
    look(4'h0); chk("R2 defined control bits", reg_rdata, 32'h0000_3031);
    chk("R7 enable not yet active", {31'd0, act_mix_en}, 32'd0);
    put(1, 4'hC, 32'hFFFF_FFFF, 0, 0, 0);
    look(4'hC); chk("R3 size fields", reg_rdata, 32'h1FFF_1FFF);
    look(4'h6); chk("R2 unmapped offset", reg_rdata, 32'd0);

    put(1, 4'h8, 32'hFFFF_FFFE, 0, 0, 0);
    look(4'h8); chk("R4 zero write ignored", reg_rdata, 32'd0);
    put(1, 4'h8, 32'h1, 0, 0, 0);
    look(4'h8); chk("R4 request latched", reg_rdata, 32'd1);
    chk("R7 width held before commit", {19'd0, act_width_m1}, 32'd0);

    put(0, 4'h4, 0, 1, 0, 0);
    look(4'h4);
    chk("R5 committed width", {19'd0, act_width_m1}, 32'h1FFF);
    chk("R5 committed wb port", {30'd0, act_wb_port}, 32'd3);
    chk("R11 busy after start", reg_rdata, 32'h10);
    look(4'h8); chk("R5 request cleared", reg_rdata, 32'd0);

    put(0, 4'h4, 0, 0, 1, 0);
    look(4'h4); chk("R8 finish set, R11 busy cleared", reg_rdata, 32'h1);
    chk("R10 finish irq", {31'd0, irq}, 32'd1);
    put(1, 4'h4, 32'h1, 0, 0, 0);
    look(4'h4); chk("R9 finish cleared", reg_rdata, 32'd0);
    chk("R10 irq dropped", {31'd0, irq}, 32'd0);

    put(0, 4'h4, 0, 0, 0, 1);
    look(4'h4); chk("R8 R12 error bits", reg_rdata, 32'h22);
    put(0, 4'h4, 0, 1, 0, 0);
    look(4'h4); chk("R12 cleared by start, R11 busy", reg_rdata, 32'h12);
    chk("R5 no request keeps width", {19'd0, act_width_m1}, 32'h1FFF);

    put(1, 4'h4, 32'h2, 0, 1, 0);
    put(1, 4'h4, 32'h1, 0, 1, 0);
    look(4'h4); chk("R9 set beats clear", reg_rdata, 32'h1);

    put(1, 4'hC, 32'h0005_0007, 0, 0, 0);
    put(1, 4'h8, 32'h1, 1, 0, 0);
    look(4'h8);
    chk("R6 same-cycle width", {19'd0, act_width_m1}, 32'd7);
    chk("R6 same-cycle height", {19'd0, act_height_m1}, 32'd5);
    chk("R6 nothing pending", reg_rdata, 32'd0);

    for (int i = 0; i < 4000; i++) begin
      logic [3:0] a;
      logic [31:0] d;
      case ($urandom % 6)
        0: a = 4'h0; 1: a = 4'h4; 2: a = 4'h8; 3: a = 4'hC;
        default: a = 4'($urandom);
      endcase
      d = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
      put(($urandom % 3) == 0, a, d, ($urandom % 7) == 0,
          ($urandom % 6) == 0, ($urandom % 11) == 0);
    end
    look(4'h0);
    finish_run();
  end
endmodule